// File: doc/BRIEF.md
# Two-Level Branch Direction and Target Predictor

This block sits in the fetch stage of a 32-bit pipelined processor. Each cycle it takes the current fetch address and returns, in the same cycle, a taken/not-taken guess and a 32-bit next-address guess. Both values are meant to travel down the pipe with the fetched instruction, so that the execute stage can later compare them with the real outcome. The predictor only guesses "taken" for branches it has already seen taken.

Two tables hold the state. The target table is direct-mapped on the low word-address bits. Each entry keeps a valid flag, a partial tag made of the remaining upper address bits, and the destination address. The direction table holds saturating counters, either 1 or 2 bits wide by parameter. It is split into two banks, and a single global history bit, the outcome of the most recent resolved branch, chooses the bank. When the execute stage resolves a branch, it presents the address, the outcome and the real destination on the training port. Training steps the counter in the bank chosen by the current history bit, writes the target entry when the branch was taken, and then loads the outcome into the history bit.

Top module: `bpred_top`

## Requirements
- R1: During synchronous active-high reset and after it, every target entry is invalid, every counter holds its weakly not-taken value (1 for 2-bit counters, 0 for 1-bit counters) and the history bit is 0. Lookups after reset therefore return not-taken with a predicted address of fetch address + 4.
- R2: A lookup whose target entry is invalid, or holds a tag different from the fetch address tag, returns not-taken and fetch address + 4.
- R3: A lookup that hits a valid entry with a matching tag, and whose selected counter is in a taken state, returns taken and the stored destination address.
- R4: A lookup that hits but whose selected counter is in a not-taken state returns not-taken and fetch address + 4.
- R5: The target table is written only by a taken resolution. The write sets the valid flag and stores the tag and destination. A not-taken resolution leaves every target entry unchanged.
- R6: With 2-bit counters the states are 0 to 3 and states 2 and 3 predict taken. Each resolution moves the selected counter one step toward its outcome and saturates at 0 and 3.
- R7: Lookup and training both use the bank selected by the global history bit as it stands in that cycle. After a resolution the history bit equals that resolution's outcome. With no resolution it holds its value.
- R8: Addresses are word aligned and bits [1:0] are ignored. The target index is fetch address bits [log2(TGT_ENTRIES)+1:2] and the tag is all higher bits. The counter index inside a bank is bits [log2(DIR_ENTRIES)+1:2].
- R9: When a lookup and a resolution fall in the same cycle, the lookup sees the table and history contents from before that cycle's update.
- R10: With CTR_BITS = 1 each counter is a single bit that predicts taken when set. It is set by a taken resolution and cleared by a not-taken one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Fetch address being looked up |
| pred_taken | output | 1 | Direction guess for fetch_pc |
| pred_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| upd_target | input | 32 | Actual destination of the resolved branch |

## Verification
The assertions assume two things about the inputs. Reset is held high at the first clock edge. Any resolution presented on the training port carries a word-aligned address with bits [1:0] at zero. The stimulus holds reset high from time zero and always builds addresses as a tag, an index and two zero bits. The tags come from a small pool, so tag hits, tag aliasing and same-index collisions between lookup and training all occur often. Directed sequences add counter saturation, history bank switching and a same-cycle lookup-and-train case, and a second instance runs the 1-bit counter variant on the same stimulus.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    localparam int XLEN = 32;

    // result of a target-table probe
    typedef struct packed {
        logic            hit;
        logic [XLEN-1:0] dest;
    } tgt_probe_t;

    // one resolved branch from the execute stage
    typedef struct packed {
        logic            valid;
        logic            taken;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] dest;
    } resolve_t;

    // counter helpers; counters are carried in 2 bits, width picks the range
    function automatic logic [1:0] ctr_max(input int unsigned width);
        return (width == 1) ? 2'd1 : 2'd3;
    endfunction

    function automatic logic [1:0] ctr_weak_nt(input int unsigned width);
        return (width == 1) ? 2'd0 : 2'd1;
    endfunction

    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up,
                                            input int unsigned width);
        logic [1:0] r;
        r = c;
        if (up && (c != ctr_max(width)))
            r = c + 2'd1;
        else if (!up && (c != 2'd0))
            r = c - 2'd1;
        return r;
    endfunction

endpackage

// File: rtl/bpred_ghist.sv
module bpred_ghist (
    input  logic clk,
    input  logic rst,
    input  logic upd_en,
    input  logic upd_taken,
    output logic ghist
);

    always_ff @(posedge clk) begin
        if (rst)
            ghist <= 1'b0;
        else if (upd_en)
            ghist <= upd_taken;
    end

    AST_GHIST_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(ghist)); // R7

endmodule

// File: rtl/bpred_tgt_table.sv
module bpred_tgt_table
    import bpred_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int TAG_W   = XLEN - IDX_W - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output tgt_probe_t       probe,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [XLEN-1:0]  wr_dest
);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [XLEN-1:0]    dest_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst)
                valid_q[e] <= 1'b0;
            else if (sel)
                valid_q[e] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst && sel) begin
                tag_q[e]  <= wr_tag;
                dest_q[e] <= wr_dest;
            end
        end
    end

    // asynchronous read: same-cycle writes are not visible until the edge
    always_comb begin
        probe.hit  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        probe.dest = dest_q[rd_idx];
    end

    AST_TGT_QUIET_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(valid_q)); // R5

    AST_TGT_VALID_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid_q[$past(wr_idx)]); // R5

endmodule

// File: rtl/bpred_dir_table.sv
module bpred_dir_table
    import bpred_pkg::*;
#(
    parameter int ENTRIES  = 16,
    parameter int CTR_BITS = 2,
    parameter int IDX_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_bank,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int SLOTS = 2 * ENTRIES;
    localparam int SEL_W = IDX_W + 1;

    logic [CTR_BITS-1:0] ctr_q [SLOTS];
    logic [SEL_W-1:0]    rd_sel;
    logic [SEL_W-1:0]    wr_sel;
    logic [1:0]          rd_wide;
    logic [1:0]          wr_wide;
    logic [1:0]          wr_next;

    assign rd_sel  = {rd_bank, rd_idx};
    assign wr_sel  = {wr_bank, wr_idx};
    assign rd_wide = 2'(ctr_q[rd_sel]);
    assign wr_wide = 2'(ctr_q[wr_sel]);
    assign wr_next = ctr_step(wr_wide, wr_taken, CTR_BITS);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SLOTS; s++)
                ctr_q[s] <= CTR_BITS'(ctr_weak_nt(CTR_BITS));
        end else if (wr_en) begin
            ctr_q[wr_sel] <= CTR_BITS'(wr_next);
        end
    end

    // the counter width picks how the direction is read out
    if (CTR_BITS == 1) begin : g_one_bit
        assign rd_taken = rd_wide[0];
    end else begin : g_two_bit
        assign rd_taken = rd_wide[1];
    end

    AST_CTR_RISES_ON_TAKEN: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_taken |=> ctr_q[$past(wr_sel)] >= $past(ctr_q[wr_sel])); // R6

    AST_CTR_FALLS_ON_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_taken |=> ctr_q[$past(wr_sel)] <= $past(ctr_q[wr_sel])); // R6

    AST_CTR_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_en && (ctr_q[wr_sel] == '0) |=> ctr_q[$past(wr_sel)] <= CTR_BITS'(1)); // R6

endmodule

// File: rtl/bpred_top.sv
module bpred_top
    import bpred_pkg::*;
#(
    parameter int TGT_ENTRIES = 16,
    parameter int DIR_ENTRIES = 16,
    parameter int CTR_BITS    = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] fetch_pc,
    output logic            pred_taken,
    output logic [XLEN-1:0] pred_pc,
    input  logic            upd_valid,
    input  logic [XLEN-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [XLEN-1:0] upd_target
);

    localparam int TIDX_W = $clog2(TGT_ENTRIES);
    localparam int DIDX_W = $clog2(DIR_ENTRIES);
    localparam int TAG_W  = XLEN - TIDX_W - 2;

    resolve_t   res;
    tgt_probe_t probe;
    logic       ghist;
    logic       dir_taken;

    assign res = '{valid: upd_valid, taken: upd_taken, pc: upd_pc, dest: upd_target};

    bpred_ghist u_ghist (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (res.valid),
        .upd_taken (res.taken),
        .ghist     (ghist)
    );

    bpred_tgt_table #(
        .ENTRIES (TGT_ENTRIES)
    ) u_tgt (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (fetch_pc[TIDX_W+1:2]),
        .rd_tag  (fetch_pc[XLEN-1:TIDX_W+2]),
        .probe   (probe),
        .wr_en   (res.valid && res.taken),
        .wr_idx  (res.pc[TIDX_W+1:2]),
        .wr_tag  (res.pc[XLEN-1:TIDX_W+2]),
        .wr_dest (res.dest)
    );

    bpred_dir_table #(
        .ENTRIES  (DIR_ENTRIES),
        .CTR_BITS (CTR_BITS)
    ) u_dir (
        .clk      (clk),
        .rst      (rst),
        .rd_bank  (ghist),
        .rd_idx   (fetch_pc[DIDX_W+1:2]),
        .rd_taken (dir_taken),
        .wr_en    (res.valid),
        .wr_bank  (ghist),
        .wr_idx   (res.pc[DIDX_W+1:2]),
        .wr_taken (res.taken)
    );

    assign pred_taken = probe.hit && dir_taken;
    assign pred_pc    = pred_taken ? probe.dest : fetch_pc + XLEN'(4);

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> probe.hit); // R3

    AST_RESET_FORGETS: assert property (@(posedge clk)
        rst |=> !pred_taken); // R1

    AST_UPD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> (upd_pc[1:0] == 2'b00)); // R8

    initial begin
        assert (TAG_W > 0);
    end

endmodule

// File: tb/bpred_top_test.sv
module bpred_top_test;

    localparam int TE = 16;
    localparam int DE = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        p2_taken, p1_taken;
    logic [31:0] p2_pc, p1_pc;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bpred_top #(.TGT_ENTRIES(TE), .DIR_ENTRIES(DE), .CTR_BITS(2)) uut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .pred_taken(p2_taken), .pred_pc(p2_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target));

    bpred_top #(.TGT_ENTRIES(TE), .DIR_ENTRIES(DE), .CTR_BITS(1)) uut1 (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .pred_taken(p1_taken), .pred_pc(p1_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target));

    // ---- reference model built from the requirements ----
    logic        m_valid [TE];
    logic [25:0] m_tag   [TE];
    logic [31:0] m_dest  [TE];
    logic [1:0]  m_c2    [2*DE];
    logic        m_c1    [2*DE];
    logic        m_hist;

    function automatic void model_reset();
        for (int i = 0; i < TE; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_dest[i] = '0;
        end
        for (int i = 0; i < 2*DE; i++) begin
            m_c2[i] = 2'd1; m_c1[i] = 1'b0;
        end
        m_hist = 1'b0;
    endfunction

    function automatic logic m_hit(input logic [31:0] pc);
        return m_valid[pc[5:2]] && (m_tag[pc[5:2]] == pc[31:6]);
    endfunction

    function automatic logic exp_taken(input logic [31:0] pc, input logic one_bit);
        int d;
        d = {m_hist, pc[5:2]};
        if (!m_hit(pc)) return 1'b0;
        return one_bit ? m_c1[d] : m_c2[d][1];
    endfunction

    function automatic logic [31:0] exp_pc(input logic [31:0] pc, input logic one_bit);
        return exp_taken(pc, one_bit) ? m_dest[pc[5:2]] : pc + 32'd4;
    endfunction

    function automatic void model_train(input logic [31:0] pc, input logic t,
                                        input logic [31:0] dst);
        int d;
        d = {m_hist, pc[5:2]};
        if (t && m_c2[d] != 2'd3) m_c2[d] = m_c2[d] + 2'd1;
        else if (!t && m_c2[d] != 2'd0) m_c2[d] = m_c2[d] - 2'd1;
        m_c1[d] = t;
        if (t) begin
            m_valid[pc[5:2]] = 1'b1;
            m_tag[pc[5:2]]   = pc[31:6];
            m_dest[pc[5:2]]  = dst;
        end
        m_hist = t;
    endfunction

    task automatic check(input string tag, input logic gt, input logic et,
                         input logic [31:0] gp, input logic [31:0] ep);
        checks++;
        if (gt !== et || gp !== ep) begin
            fails++;
            $display("FAIL %s: taken=%0b pc=%08h expected taken=%0b pc=%08h",
                     tag, gt, gp, et, ep);
        end
    endtask

    // one cycle: drive lookup and optional training, check, then advance model
    task automatic vec(input logic [31:0] fpc, input logic uv, input logic [31:0] upc,
                       input logic ut, input logic [31:0] udst, input string tag);
        string t2, t1;
        @(negedge clk);
        fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = udst;
        #1;
        if (tag != "") t2 = tag;
        else if (!m_hit(fpc)) t2 = "R2";
        else if (exp_taken(fpc, 1'b0)) t2 = "R3";
        else t2 = "R4";
        t1 = (tag != "") ? {tag, "/R10"} : "R10";
        check(t2, p2_taken, exp_taken(fpc, 1'b0), p2_pc, exp_pc(fpc, 1'b0));
        check(t1, p1_taken, exp_taken(fpc, 1'b1), p1_pc, exp_pc(fpc, 1'b1));
        @(posedge clk);
        #1;
        if (uv) model_train(upc, ut, udst);
    endtask

    function automatic logic [31:0] rnd_pc();
        logic [25:0] tg;
        logic [3:0]  ix;
        tg = 26'h0123 + 26'($urandom % 3);
        ix = 4'($urandom % 8);
        return {tg, ix, 2'b00};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] a, b;
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty predictor after reset
        vec(32'h0000_1000, 1'b0, '0, 1'b0, '0, "R1");
        vec(32'h8000_003C, 1'b0, '0, 1'b0, '0, "R1");

        a = 32'h0000_48C8;                 // index 2
        b = 32'h0001_48C8;                 // same index, other tag
        // R6/R7: train taken repeatedly; bank follows history
        vec(a, 1'b1, a, 1'b1, 32'h0000_2000, "R9");  // same-cycle: old contents
        vec(a, 1'b0, '0, 1'b0, '0, "R7");            // hist=1, bank1 still weak
        vec(a, 1'b1, a, 1'b1, 32'h0000_2000, "R7");
        vec(a, 1'b1, a, 1'b1, 32'h0000_2000, "R6");
        vec(a, 1'b1, a, 1'b1, 32'h0000_2000, "R6");
        vec(a, 1'b0, '0, 1'b0, '0, "R6");            // bank1 saturated at 3
        // R8: alias in target index with a different tag misses
        vec(b, 1'b0, '0, 1'b0, '0, "R8");
        // R5: not-taken training leaves the target entry
        vec(a, 1'b1, a, 1'b0, 32'h0000_3000, "R5");
        vec(a, 1'b1, a, 1'b1, 32'h0000_2000, "R5");
        vec(a, 1'b0, '0, 1'b0, '0, "R5");
        // R9: lookup and retarget in the same cycle
        vec(a, 1'b1, a, 1'b1, 32'h0000_4440, "R9");
        vec(a, 1'b0, '0, 1'b0, '0, "R3");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] f, u;
            logic        uv, ut;
            f  = rnd_pc();
            u  = ($urandom % 4 == 0) ? f : rnd_pc();
            uv = ($urandom % 3 != 0);
            ut = ($urandom % 5 < 3);
            vec(f, uv, u, ut, {16'h00A0, 14'($urandom), 2'b00}, "");
        end

        // R1: reset again mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        upd_valid = 1'b0;
        @(posedge clk);
        #1;
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        vec(a, 1'b0, '0, 1'b0, '0, "R1");

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule